// File: doc/BRIEF.md
# Indirect Command-Port DMA Channel Programmer

This block is the host-facing programming front end of an eight-channel DMA controller. Software does not see a flat register map per channel. It reaches the controller through two byte-wide I/O locations. The first is a command location. A byte written there names an operation and the channel it acts on. The second is an operand location. The bytes of the operation's argument are written or read there one after another, least significant byte first.

Each channel holds five values: a 24-bit memory address, a 16-bit transfer count, a 16-bit I/O port number, a mode byte and an arbitration level. It also has a mask bit. A multi-byte argument is collected in a staging register. It reaches the channel only when its last byte arrives. The data-movement engine reads any channel's settings through a registered side port, which returns them one cycle after the channel is selected.

Top module: `dma_cmd_port`

## Requirements
- R1: The command location is I/O offset 0x18 and the operand location is offset 0x1A, on a 5-bit offset bus. A write to any other offset changes nothing. A read of any offset other than 0x1A returns 0x00.
- R2: A command byte carries the operation code in bits 7:4 and the channel in bits 3:0. Every accepted command byte restarts the operand sequence at byte 0.
- R3: Code 0x2 loads and code 0x3 returns the 24-bit address as three operand bytes, bits 7:0 first and bits 23:16 last.
- R4: Code 0x4 loads and code 0x5 returns the 16-bit count as two operand bytes, low byte first. Software writes the number of transfers minus one. Readback returns exactly the stored value.
- R5: Code 0x0 loads the 16-bit I/O port number as two operand bytes, low byte first. The engine port shows it.
- R6: Code 0x7 takes one mode byte, which the engine port decodes as follows: bit 2 enables transfer, bit 3 selects the memory-write direction (clear means memory-read), bit 0 selects an I/O-port target, and bit 6 selects 16-bit transfers.
- R7: Code 0x8 takes one byte. Its bits 3:0 become the channel's arbitration level and bits 7:4 are dropped.
- R8: Code 0x9 masks and code 0xA unmasks the named channel, with no operand bytes. Code 0x6 returns one status byte in which bit n is 1 when channel n is masked.
- R9: Reset and code 0xD, whatever its channel nibble, mask every channel, zero every address, count, port, mode and level, and leave no command active.
- R10: A channel value changes only when the final operand byte of its command is written. A sequence that a new command byte abandons leaves the value unchanged.
- R11: Operand writes beyond the current command's length, or during a read command, are ignored. Operand reads beyond the length, or during a load command, return 0x00 and do not advance the sequence.
- R12: A command byte naming channel 8 or above, or an undefined operation code (other than a master clear), is ignored as a whole, and the command in progress carries on.
- R13: Read data appears on io_rdata with io_rvalid high in the cycle after io_rd, and io_rvalid is low again one cycle later. The engine port outputs follow eng_ch with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 5 | I/O offset of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data byte |
| io_rvalid | output | 1 | io_rdata holds the answer to the previous cycle's read |
| eng_ch | input | 3 | Channel selected by the engine |
| eng_addr | output | 24 | Address of the selected channel |
| eng_count | output | 16 | Stored count (transfers minus one) |
| eng_port | output | 16 | I/O port number |
| eng_xfer_en | output | 1 | Mode: transfer enabled |
| eng_mem_write | output | 1 | Mode: memory-write direction |
| eng_io_target | output | 1 | Mode: I/O-port target |
| eng_wide | output | 1 | Mode: 16-bit transfers |
| eng_arb | output | 4 | Arbitration level |
| eng_masked | output | 1 | Channel mask bit |

## Verification
The bench programs every channel with its own arithmetic pattern of address, count, port, mode bits and level. It then reads all of them back, so a swapped byte lane, a wrong channel index or a wrong mode decode shows up as a mismatch on one channel. Unmasking only the even channels gives a status byte of 0xAA, which separates a correct bit order from a reversed or shifted one. Several sequences interrupt or overrun operands: abandoned loads, surplus bytes, illegal channels and undefined codes injected mid-sequence, and writes at wrong offsets. These separate the staged-commit and ignore rules from designs that write each byte straight through. A master clear with a nonzero channel nibble finishes the run.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int PORT_W = 16;
  localparam int ARB_W  = 4;
  localparam int OFS_W  = 5;
  localparam logic [OFS_W-1:0] CMD_OFS = 5'h18;
  localparam logic [OFS_W-1:0] OPR_OFS = 5'h1A;

  localparam logic [3:0] OP_SET_PORT = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_GET_STAT = 4'h6;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_SET_ARB  = 4'h8;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;
  localparam logic [3:0] OP_CLEAR    = 4'hD;

  function automatic logic [1:0] op_len(input logic [3:0] op);
    case (op)
      OP_SET_ADDR, OP_GET_ADDR:            op_len = 2'd3;
      OP_SET_PORT, OP_SET_CNT, OP_GET_CNT: op_len = 2'd2;
      OP_GET_STAT, OP_SET_MODE, OP_SET_ARB: op_len = 2'd1;
      default:                             op_len = 2'd0;
    endcase
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    case (op)
      OP_SET_PORT, OP_SET_ADDR, OP_GET_ADDR, OP_SET_CNT, OP_GET_CNT,
      OP_GET_STAT, OP_SET_MODE, OP_SET_ARB, OP_MASK, OP_UNMASK,
      OP_CLEAR: op_known = 1'b1;
      default:  op_known = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_get(input logic [3:0] op);
    op_is_get = (op == OP_GET_ADDR) || (op == OP_GET_CNT) || (op == OP_GET_STAT);
  endfunction
endpackage

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dma_cmd_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [7:0]      cmd_byte,
  input  logic            opr_wr,
  input  logic            opr_rd,
  output logic [3:0]      cur_op,
  output logic [CH_W-1:0] cur_ch,
  output logic [1:0]      ptr,
  output logic            opr_wr_ok,
  output logic            opr_rd_ok,
  output logic            last_byte,
  output logic            mask_ev,
  output logic            unmask_ev,
  output logic            clear_ev,
  output logic [CH_W-1:0] ev_ch
);
  logic       active;
  logic [3:0] in_op;
  logic [3:0] in_ch;
  logic       ch_ok;
  logic       accept;
  logic [1:0] cur_len;

  assign in_op   = cmd_byte[7:4];
  assign in_ch   = cmd_byte[3:0];
  assign ch_ok   = int'(in_ch) < NCH;
  assign accept  = cmd_wr && op_known(in_op) && (ch_ok || in_op == OP_CLEAR);
  assign cur_len = op_len(cur_op);

  assign clear_ev  = accept && (in_op == OP_CLEAR);
  assign mask_ev   = accept && (in_op == OP_MASK);
  assign unmask_ev = accept && (in_op == OP_UNMASK);
  assign ev_ch     = in_ch[CH_W-1:0];

  assign opr_wr_ok = active && opr_wr && !op_is_get(cur_op) && (ptr < cur_len);
  assign opr_rd_ok = active && opr_rd &&  op_is_get(cur_op) && (ptr < cur_len);
  assign last_byte = (ptr == cur_len - 2'd1);

  always_ff @(posedge clk) begin
    if (rst || clear_ev) begin
      active <= 1'b0;
      cur_op <= OP_SET_PORT;
      cur_ch <= '0;
      ptr    <= 2'd0;
    end else if (accept) begin
      active <= (op_len(in_op) != 2'd0);
      cur_op <= in_op;
      cur_ch <= in_ch[CH_W-1:0];
      ptr    <= 2'd0;
    end else if (opr_wr_ok || opr_rd_ok) begin
      ptr <= ptr + 2'd1;
    end
  end

  // R11
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> ptr <= cur_len);

  // R2
  ptr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> ptr == 2'd0);

  // R12
  bad_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !accept && !opr_wr && !opr_rd) |=> ($stable(cur_op) && $stable(ptr) && $stable(cur_ch)));
endmodule

// File: rtl/dma_cmd_stage.sv
module dma_cmd_stage
  import dma_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              last_byte,
  input  logic [1:0]        ptr,
  input  logic [7:0]        din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_val
);
  localparam int HOLD_W = ADDR_W - 8;

  logic [HOLD_W-1:0] hold_q;

  assign commit = load && last_byte;

  always_comb begin
    commit_val = {8'h00, hold_q};
    case (ptr)
      2'd0:    commit_val[7:0]   = din;
      2'd1:    commit_val[15:8]  = din;
      default: commit_val[23:16] = din;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load && !last_byte) begin
      if (ptr == 2'd0) hold_q[7:0]  <= din;
      else             hold_q[15:8] <= din;
    end
  end

  // R10
  stage_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !last_byte) |-> ptr < 2'd2);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cmd_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [3:0]        wr_op,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [ADDR_W-1:0] wr_val,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic [CH_W-1:0]   mask_ch,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] host_addr,
  output logic [CNT_W-1:0]  host_cnt,
  output logic [NCH-1:0]    mask_vec,
  input  logic [CH_W-1:0]   eng_ch,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [CNT_W-1:0]  eng_cnt,
  output logic [PORT_W-1:0] eng_port,
  output logic [7:0]        eng_mode,
  output logic [ARB_W-1:0]  eng_arb,
  output logic              eng_masked
);
  logic [ADDR_W-1:0] addr_q [NCH];
  logic [CNT_W-1:0]  cnt_q  [NCH];
  logic [PORT_W-1:0] port_q [NCH];
  logic [7:0]        mode_q [NCH];
  logic [ARB_W-1:0]  arb_q  [NCH];
  logic [NCH-1:0]    mask_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        port_q[i] <= '0;
        mode_q[i] <= '0;
        arb_q[i]  <= '0;
      end
      mask_q <= '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && int'(wr_ch) == i) begin
          case (wr_op)
            OP_SET_ADDR: addr_q[i] <= wr_val;
            OP_SET_CNT:  cnt_q[i]  <= wr_val[CNT_W-1:0];
            OP_SET_PORT: port_q[i] <= wr_val[PORT_W-1:0];
            OP_SET_MODE: mode_q[i] <= wr_val[7:0];
            OP_SET_ARB:  arb_q[i]  <= wr_val[ARB_W-1:0];
            default: ;
          endcase
        end
        if (mask_set && int'(mask_ch) == i)      mask_q[i] <= 1'b1;
        else if (mask_clr && int'(mask_ch) == i) mask_q[i] <= 1'b0;
      end
    end
  end

  assign host_addr = addr_q[rd_ch];
  assign host_cnt  = cnt_q[rd_ch];
  assign mask_vec  = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_addr   <= '0;
      eng_cnt    <= '0;
      eng_port   <= '0;
      eng_mode   <= '0;
      eng_arb    <= '0;
      eng_masked <= 1'b1;
    end else begin
      eng_addr   <= addr_q[eng_ch];
      eng_cnt    <= cnt_q[eng_ch];
      eng_port   <= port_q[eng_ch];
      eng_mode   <= mode_q[eng_ch];
      eng_arb    <= arb_q[eng_ch];
      eng_masked <= mask_q[eng_ch];
    end
  end

  // R9
  clear_masks_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> &mask_vec);

  // R8
  unmask_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_clr && !clr) |=> !mask_vec[$past(mask_ch)]);
endmodule

// File: rtl/dma_cmd_port.sv
module dma_cmd_port
  import dma_cmd_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  input  logic [CH_W-1:0]   eng_ch,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [CNT_W-1:0]  eng_count,
  output logic [PORT_W-1:0] eng_port,
  output logic              eng_xfer_en,
  output logic              eng_mem_write,
  output logic              eng_io_target,
  output logic              eng_wide,
  output logic [ARB_W-1:0]  eng_arb,
  output logic              eng_masked
);
  localparam int STAT_N = (NCH < 8) ? NCH : 8;

  logic              cmd_wr, opr_wr, opr_rd;
  logic [3:0]        cur_op;
  logic [CH_W-1:0]   cur_ch, ev_ch;
  logic [1:0]        ptr;
  logic              opr_wr_ok, opr_rd_ok, last_byte;
  logic              mask_ev, unmask_ev, clear_ev;
  logic              commit;
  logic [ADDR_W-1:0] commit_val;
  logic [ADDR_W-1:0] host_addr;
  logic [CNT_W-1:0]  host_cnt;
  logic [NCH-1:0]    mask_vec;
  logic [7:0]        eng_mode;
  logic [7:0]        stat_byte;
  logic [7:0]        rd_byte;

  assign cmd_wr = io_wr && (io_addr == CMD_OFS);
  assign opr_wr = io_wr && (io_addr == OPR_OFS);
  assign opr_rd = io_rd && (io_addr == OPR_OFS);

  dma_cmd_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(io_wdata),
    .opr_wr(opr_wr), .opr_rd(opr_rd), .cur_op(cur_op), .cur_ch(cur_ch),
    .ptr(ptr), .opr_wr_ok(opr_wr_ok), .opr_rd_ok(opr_rd_ok),
    .last_byte(last_byte), .mask_ev(mask_ev), .unmask_ev(unmask_ev),
    .clear_ev(clear_ev), .ev_ch(ev_ch)
  );

  dma_cmd_stage u_stage (
    .clk(clk), .rst(rst), .load(opr_wr_ok), .last_byte(last_byte),
    .ptr(ptr), .din(io_wdata), .commit(commit), .commit_val(commit_val)
  );

  dma_chan_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .clr(clear_ev), .wr_en(commit), .wr_op(cur_op),
    .wr_ch(cur_ch), .wr_val(commit_val), .mask_set(mask_ev),
    .mask_clr(unmask_ev), .mask_ch(ev_ch), .rd_ch(cur_ch),
    .host_addr(host_addr), .host_cnt(host_cnt), .mask_vec(mask_vec),
    .eng_ch(eng_ch), .eng_addr(eng_addr), .eng_cnt(eng_count),
    .eng_port(eng_port), .eng_mode(eng_mode), .eng_arb(eng_arb),
    .eng_masked(eng_masked)
  );

  generate
    for (genvar b = 0; b < 8; b++) begin : g_stat
      if (b < STAT_N) begin : g_live
        assign stat_byte[b] = mask_vec[b];
      end else begin : g_pad
        assign stat_byte[b] = 1'b0;
      end
    end
  endgenerate

  assign eng_io_target = eng_mode[0];
  assign eng_xfer_en   = eng_mode[2];
  assign eng_mem_write = eng_mode[3];
  assign eng_wide      = eng_mode[6];

  always_comb begin
    rd_byte = 8'h00;
    if (opr_rd_ok) begin
      case (cur_op)
        OP_GET_ADDR: begin
          case (ptr)
            2'd0:    rd_byte = host_addr[7:0];
            2'd1:    rd_byte = host_addr[15:8];
            default: rd_byte = host_addr[23:16];
          endcase
        end
        OP_GET_CNT:  rd_byte = (ptr == 2'd0) ? host_cnt[7:0] : host_cnt[15:8];
        OP_GET_STAT: rd_byte = stat_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= 8'h00;
      io_rvalid <= 1'b0;
    end else begin
      io_rdata  <= rd_byte;
      io_rvalid <= io_rd;
    end
  end

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !opr_rd_ok) |=> io_rdata == 8'h00);

  // R10
  commit_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (opr_wr && ptr == op_len(cur_op) - 2'd1));
endmodule

// File: tb/sim_dma_cmd_port.sv
`timescale 1ns/1ps
module sim_dma_cmd_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  io_addr = 5'h00;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [2:0]  eng_ch = 3'd0;
  logic [23:0] eng_addr;
  logic [15:0] eng_count, eng_port;
  logic        eng_xfer_en, eng_mem_write, eng_io_target, eng_wide, eng_masked;
  logic [3:0]  eng_arb;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_cmd_port u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .eng_ch(eng_ch), .eng_addr(eng_addr), .eng_count(eng_count),
    .eng_port(eng_port), .eng_xfer_en(eng_xfer_en), .eng_mem_write(eng_mem_write),
    .eng_io_target(eng_io_target), .eng_wide(eng_wide), .eng_arb(eng_arb),
    .eng_masked(eng_masked)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr_at(input logic [4:0] ofs, input logic [7:0] d);
    @(negedge clk);
    io_addr = ofs; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [3:0] ch);
    wr_at(5'h18, {op, ch});
  endtask

  task automatic opw(input logic [7:0] d);
    wr_at(5'h1A, d);
  endtask

  task automatic rd_at(input logic [4:0] ofs, output logic [7:0] d);
    @(negedge clk);
    io_addr = ofs; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check("R13 rvalid after read", {31'd0, io_rvalid}, 32'd1);
    d = io_rdata;
  endtask

  task automatic get24(input logic [3:0] ch, output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    cmd(4'h3, ch);
    rd_at(5'h1A, b0); rd_at(5'h1A, b1); rd_at(5'h1A, b2);
    v = {b2, b1, b0};
  endtask

  task automatic get16(input logic [3:0] ch, output logic [15:0] v);
    logic [7:0] b0, b1;
    cmd(4'h5, ch);
    rd_at(5'h1A, b0); rd_at(5'h1A, b1);
    v = {b1, b0};
  endtask

  task automatic get_stat(output logic [7:0] v);
    cmd(4'h6, 4'h0);
    rd_at(5'h1A, v);
  endtask

  task automatic eng_sel(input logic [2:0] ch);
    @(negedge clk);
    eng_ch = ch;
    @(negedge clk);
  endtask

  function automatic logic [23:0] addr_of(input int ch);
    return 24'((ch + 1) * 32'h0A1B2C);
  endfunction
  function automatic logic [15:0] cnt_of(input int ch);
    return 16'(32'h0100 * ch + 32'h00FF - ch);
  endfunction
  function automatic logic [15:0] port_of(input int ch);
    return 16'(32'h0300 + ch * 32'h11);
  endfunction
  function automatic logic [7:0] mode_of(input int ch);
    return 8'h04 | ((ch & 1) != 0 ? 8'h01 : 8'h00) | ((ch & 2) != 0 ? 8'h08 : 8'h00)
                 | ((ch & 4) != 0 ? 8'h40 : 8'h00);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] a;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R13 rvalid idle", {31'd0, io_rvalid}, 32'd0);
    eng_sel(3'd5);
    check("R9 reset masked", {31'd0, eng_masked}, 32'd1);
    check("R9 reset addr", {8'd0, eng_addr}, 32'd0);
    get_stat(b);
    check("R9 reset status", {24'd0, b}, 32'hFF);
    @(negedge clk);
    check("R13 rvalid drops", {31'd0, io_rvalid}, 32'd0);

    // program every channel
    for (int ch = 0; ch < 8; ch++) begin
      cmd(4'h0, 4'(ch)); opw(port_of(ch)[7:0]); opw(port_of(ch)[15:8]);
      cmd(4'h2, 4'(ch)); opw(addr_of(ch)[7:0]); opw(addr_of(ch)[15:8]); opw(addr_of(ch)[23:16]);
      cmd(4'h4, 4'(ch)); opw(cnt_of(ch)[7:0]); opw(cnt_of(ch)[15:8]);
      cmd(4'h7, 4'(ch)); opw(mode_of(ch));
      cmd(4'h8, 4'(ch)); opw(8'hA0 | 8'(ch * 3));
      if (ch % 2 == 0) cmd(4'hA, 4'(ch));
    end

    for (int ch = 0; ch < 8; ch++) begin
      get24(4'(ch), a);
      check("R3 address readback", {8'd0, a}, {8'd0, addr_of(ch)});
      rd_at(5'h1A, b);
      check("R11 read past length", {24'd0, b}, 32'd0);
      get16(4'(ch), c);
      check("R4 count readback", {16'd0, c}, {16'd0, cnt_of(ch)});
      eng_sel(3'(ch));
      check("R3 engine address", {8'd0, eng_addr}, {8'd0, addr_of(ch)});
      check("R4 engine count", {16'd0, eng_count}, {16'd0, cnt_of(ch)});
      check("R5 engine port", {16'd0, eng_port}, {16'd0, port_of(ch)});
      check("R6 io target", {31'd0, eng_io_target}, (ch & 1) != 0 ? 32'd1 : 32'd0);
      check("R6 xfer enable", {31'd0, eng_xfer_en}, 32'd1);
      check("R6 mem write", {31'd0, eng_mem_write}, (ch & 2) != 0 ? 32'd1 : 32'd0);
      check("R6 wide", {31'd0, eng_wide}, (ch & 4) != 0 ? 32'd1 : 32'd0);
      check("R7 arbitration", {28'd0, eng_arb}, 32'((ch * 3) & 15));
      check("R8 engine mask", {31'd0, eng_masked}, (ch % 2) != 0 ? 32'd1 : 32'd0);
    end
    get_stat(b);
    check("R8 status even unmasked", {24'd0, b}, 32'hAA);
    cmd(4'h9, 4'h2);
    get_stat(b);
    check("R8 mask ch2", {24'd0, b}, 32'hAE);

    // R10 abandoned load
    cmd(4'h2, 4'h2); opw(8'h11); opw(8'h22);
    get24(4'h2, a);
    check("R10 partial load discarded", {8'd0, a}, {8'd0, addr_of(2)});

    // R11 surplus operand byte
    cmd(4'h4, 4'h3); opw(8'h34); opw(8'h12); opw(8'h99);
    get16(4'h3, c);
    check("R11 surplus write ignored", {16'd0, c}, 32'h1234);
    cmd(4'h4, 4'h3);
    rd_at(5'h1A, b);
    check("R11 read during load", {24'd0, b}, 32'd0);
    opw(8'h78); opw(8'h56);
    get16(4'h3, c);
    check("R11 read did not advance", {16'd0, c}, 32'h5678);

    // R12 illegal channel and unknown code mid-sequence
    cmd(4'h2, 4'h4); opw(8'hC3);
    cmd(4'h9, 4'h9);
    opw(8'hB2);
    cmd(4'hB, 4'h1);
    opw(8'hA1);
    get24(4'h4, a);
    check("R12 sequence survives", {8'd0, a}, 32'hA1B2C3);
    get_stat(b);
    check("R12 channel 9 mask ignored", {24'd0, b}, 32'hAE);

    // R1 wrong offsets
    wr_at(5'h19, 8'h90);
    wr_at(5'h1B, 8'h90);
    get_stat(b);
    check("R1 stray write ignored", {24'd0, b}, 32'hAE);
    cmd(4'h6, 4'h0);
    rd_at(5'h1C, b);
    check("R1 stray read zero", {24'd0, b}, 32'd0);
    rd_at(5'h18, b);
    check("R1 command read zero", {24'd0, b}, 32'd0);

    // R2 restart on repeated command
    cmd(4'h2, 4'h5); opw(8'hEE);
    cmd(4'h2, 4'h5); opw(8'h01); opw(8'h02); opw(8'h03);
    get24(4'h5, a);
    check("R2 sequence restarts", {8'd0, a}, 32'h030201);

    // R9 master clear with nonzero channel nibble
    cmd(4'hD, 4'hF);
    get_stat(b);
    check("R9 clear masks all", {24'd0, b}, 32'hFF);
    get24(4'h1, a);
    check("R9 clear address", {8'd0, a}, 32'd0);
    eng_sel(3'd6);
    check("R9 clear port", {16'd0, eng_port}, 32'd0);
    check("R9 clear mode", {28'd0, eng_xfer_en, eng_mem_write, eng_io_target, eng_wide}, 32'd0);
    opw(8'h55);
    get16(4'h0, c);
    check("R9 no command after clear", {16'd0, c}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule